// File: doc/BRIEF.md
# Oversampling UART Receiver

This block recovers asynchronous serial characters from a single receive line. An enable pulse supplied from outside, at sixteen times the bit rate, paces an internal frame state machine. The state machine finds the falling edge of a start bit and confirms it at mid-bit. It then takes one sample at the centre of every data, parity and stop bit and builds the character in a shift register. When the last stop bit has been sampled, the character moves into a holding register together with its status flags, and a one-cycle interrupt request is raised.

The framing options can be changed at run time. A character is 7, 8 or 9 bits long. Parity is none, odd or even. There are one or two stop bits. Bits arrive least significant first or most significant first. The character and parity bits may be logically inverted, and the whole line may be inverted at the pin. If software fails to read a character before the next one is nearly complete, an overrun is declared. An optional ready-to-receive output tells the far end whether the holding register has room.

The frame state machine has six states. IDLE waits for a low level on an oversampling tick and goes to START. START re-samples after half a bit: a high level there is a glitch and goes back to IDLE, a low level goes to DATA. DATA stays put until the last character bit, then goes to PARITY when parity is enabled or to STOP1 when it is not. PARITY goes to STOP1. STOP1 goes to STOP2 when two stop bits are selected and to IDLE otherwise. STOP2 goes to IDLE. A low receive enable forces IDLE from any state.

Top module: `rx_oversample_uart`

## Requirements
- R1: While `rx_en` is 0 no start bit is detected and no character is transferred. Clearing `rx_en` partway through a frame discards that frame.
- R2: A start bit is accepted only if the line is still low 8 ticks after the falling edge. A low pulse shorter than that produces no character.
- R3: `char_len` selects the character length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits. The received character is right-justified in `rx_data` and the unused upper bits read 0. With `msb_first` at 0, the first data bit received is bit 0.
- R4: With `msb_first` at 1, the first data bit received is the most significant bit of the configured length.
- R5: `par_mode` 1 selects odd parity, 2 selects even parity, and 0 or 3 selects no parity bit. `err_parity` is set with the character when the count of ones over the character and parity bits has the wrong oddness.
- R6: `two_stop` at 1 expects two stop bits. `err_frame` is set with the character when any expected stop bit is sampled low.
- R7: A frame that reaches its sample of the bit just before its final stop bit while `buf_full` is 1 sets `err_overrun`. That frame is discarded: `rx_data` keeps the earlier character and no `rx_irq` is raised.
- R8: Each transfer into the holding register raises `rx_irq` for exactly one cycle and sets `buf_full`. `rx_data` changes only in that cycle.
- R9: A one-cycle `rd_strobe` clears `buf_full`, `err_overrun`, `err_frame` and `err_parity`. `err_sum` is 1 exactly when any of those three error flags is 1.
- R10: `data_inv` at 1 inverts the character and parity bits but not the start or stop bits.
- R11: `line_inv` at 1 inverts every level on `rxd`, so the idle line is low.
- R12: With `rts_en` at 1, `rts_n` is 0 while `rx_en` is 1 and `buf_full` is 0, and 1 otherwise. With `rts_en` at 0, `rts_n` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_en | input | 1 | Receive enable |
| char_len | input | 2 | Character length select (0:7, 1:8, 2:9 bits) |
| par_mode | input | 2 | Parity select (1 odd, 2 even, else none) |
| two_stop | input | 1 | Expect two stop bits |
| msb_first | input | 1 | Most significant bit arrives first |
| data_inv | input | 1 | Invert character and parity bits |
| line_inv | input | 1 | Invert all levels of the receive line |
| rts_en | input | 1 | Enable the ready-to-receive output |
| rxd | input | 1 | Serial receive line |
| rd_strobe | input | 1 | Holding register read pulse |
| rx_data | output | 9 | Received character, right-justified |
| buf_full | output | 1 | Holding register holds an unread character |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| rts_n | output | 1 | Active-low ready-to-receive |

## Verification
The hardest case to reach is an overrun, because it depends on host timing. The holding register has to stay unread while a second frame runs right up to its last stop bit. The bench gets there by switching off the scoreboard's automatic read, sending two frames back to back and then inspecting the flags and the data that was kept. Other cases also need stimulus shaped by hand: a start pulse that ends before mid-bit, a receive enable that drops during a frame, and stop bits held low only long enough to cover their sample point, so that no false start bit follows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_MAX = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    // length select: 0 -> 7 bits, 2 -> 9 bits, anything else -> 8 bits
    function automatic logic [3:0] char_bits(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 4'd7;
            2'd2:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic invert,
    output logic level
);
    logic [STAGES-1:0] chain_q;

    // polarity applied before the chain so reset means idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_in ^ invert};
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx_en,
    input  logic                line,
    input  logic [3:0]          nbits,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                msb_first,
    input  logic                data_inv,
    output logic                done,
    output logic                near_end,
    output logic [CHAR_MAX-1:0] char_out,
    output logic                par_err,
    output logic                frm_err,
    output rx_state_e           state_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_T = CNT_W'(OVS / 2 - 1);

    rx_state_e           state, nxt;
    logic [CNT_W-1:0]    cnt;
    logic [3:0]          bit_idx;
    logic [CHAR_MAX-1:0] shreg;
    logic                ones;
    logic                fe_acc;
    logic                sample, confirm, dbit, in_frame;

    assign in_frame = (state == ST_DATA) || (state == ST_PARITY) ||
                      (state == ST_STOP1) || (state == ST_STOP2);
    assign sample   = tick && in_frame && (cnt == LAST_T);
    assign confirm  = tick && (state == ST_START) && (cnt == HALF_T);
    assign dbit     = line ^ data_inv;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !line) nxt = ST_START;
            ST_START:  if (confirm) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (sample && bit_idx == nbits - 4'd1)
                           nxt = par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (sample) nxt = ST_STOP1;
            ST_STOP1:  if (sample) nxt = two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (sample) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!rx_en) nxt = ST_IDLE;
    end

    // datapath: tick counter, bit index, shift register, accumulators
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            ones    <= 1'b0;
            fe_acc  <= 1'b0;
        end else begin
            if (state != nxt)         cnt <= '0;
            else if (tick)            cnt <= (cnt == LAST_T) ? '0 : cnt + 1'b1;

            if (nxt == ST_START && state == ST_IDLE) begin
                shreg   <= '0;
                ones    <= 1'b0;
                fe_acc  <= 1'b0;
                bit_idx <= '0;
            end

            if (sample) begin
                unique case (state)
                    ST_DATA: begin
                        bit_idx <= bit_idx + 4'd1;
                        ones    <= ones ^ dbit;
                        if (msb_first) shreg <= {shreg[CHAR_MAX-2:0], dbit};
                        else           shreg <= {dbit, shreg[CHAR_MAX-1:1]};
                    end
                    ST_PARITY: ones <= ones ^ dbit;
                    ST_STOP1, ST_STOP2: if (!line) fe_acc <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        done     = rx_en && sample &&
                   ((state == ST_STOP1 && !two_stop) || state == ST_STOP2);
        near_end = rx_en && sample &&
                   ((two_stop && state == ST_STOP1) ||
                    (!two_stop && state != ST_STOP1 && nxt == ST_STOP1));
        if (msb_first) char_out = shreg;
        else           char_out = shreg >> (4'd9 - nbits);
        par_err  = par_en && (ones ^ par_odd);
        frm_err  = fe_acc || !line;
        state_o  = state;
    end
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                done,
    input  logic                near_end,
    input  logic [CHAR_MAX-1:0] char_in,
    input  logic                pe_in,
    input  logic                fe_in,
    input  logic                rd,
    input  logic                rts_en,
    output logic [CHAR_MAX-1:0] data_q,
    output logic                full_q,
    output logic                ovr_q,
    output logic                fe_q,
    output logic                pe_q,
    output logic                sum,
    output logic                irq_q,
    output logic                rts_n
);
    logic frame_lost;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            full_q     <= 1'b0;
            ovr_q      <= 1'b0;
            fe_q       <= 1'b0;
            pe_q       <= 1'b0;
            irq_q      <= 1'b0;
            frame_lost <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (rd) begin
                full_q <= 1'b0;
                ovr_q  <= 1'b0;
                fe_q   <= 1'b0;
                pe_q   <= 1'b0;
            end
            if (near_end && full_q && !rd) begin
                ovr_q      <= 1'b1;
                frame_lost <= 1'b1;
            end
            if (done) begin
                if (!frame_lost) begin
                    data_q <= char_in;
                    full_q <= 1'b1;
                    pe_q   <= pe_in;
                    fe_q   <= fe_in;
                    irq_q  <= 1'b1;
                end
                frame_lost <= 1'b0;
            end
            if (!rx_en) frame_lost <= 1'b0;
        end
    end

    assign sum   = ovr_q | fe_q | pe_q;
    assign rts_n = !(rts_en && rx_en && !full_q);
endmodule

// File: rtl/rx_oversample_uart.sv
module rx_oversample_uart
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_en,
    input  logic [1:0] char_len,
    input  logic [1:0] par_mode,
    input  logic       two_stop,
    input  logic       msb_first,
    input  logic       data_inv,
    input  logic       line_inv,
    input  logic       rts_en,
    input  logic       rxd,
    input  logic       rd_strobe,
    output logic [8:0] rx_data,
    output logic       buf_full,
    output logic       err_overrun,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_sum,
    output logic       rx_irq,
    output logic       rts_n
);
    logic                line_lvl;
    logic                xfer_w, near_w, pe_w, fe_w;
    logic [CHAR_MAX-1:0] char_w;
    rx_state_e           eng_state;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (rxd),
        .invert (line_inv),
        .level  (line_lvl)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rx_en     (rx_en),
        .line      (line_lvl),
        .nbits     (char_bits(char_len)),
        .par_en    (par_mode == 2'd1 || par_mode == 2'd2),
        .par_odd   (par_mode == 2'd1),
        .two_stop  (two_stop),
        .msb_first (msb_first),
        .data_inv  (data_inv),
        .done      (xfer_w),
        .near_end  (near_w),
        .char_out  (char_w),
        .par_err   (pe_w),
        .frm_err   (fe_w),
        .state_o   (eng_state)
    );

    uart_rx_holding u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .done     (xfer_w),
        .near_end (near_w),
        .char_in  (char_w),
        .pe_in    (pe_w),
        .fe_in    (fe_w),
        .rd       (rd_strobe),
        .rts_en   (rts_en),
        .data_q   (rx_data),
        .full_q   (buf_full),
        .ovr_q    (err_overrun),
        .fe_q     (err_frame),
        .pe_q     (err_parity),
        .sum      (err_sum),
        .irq_q    (rx_irq),
        .rts_n    (rts_n)
    );
endmodule

// File: rtl/rx_oversample_uart_sva.sv
module rx_oversample_uart_sva
    import uart_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_strobe,
    input logic       rx_irq,
    input logic       buf_full,
    input logic       err_overrun,
    input logic       err_frame,
    input logic       err_parity,
    input logic [8:0] rx_data,
    input logic       xfer_w,
    input rx_state_e  eng_state
);
    p_irq_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq |-> $stable(rx_data));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !xfer_w) |=>
            (!buf_full && !err_frame && !err_parity && !err_overrun));

    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (eng_state == ST_IDLE));
endmodule

bind rx_oversample_uart rx_oversample_uart_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rd_strobe   (rd_strobe),
    .rx_irq      (rx_irq),
    .buf_full    (buf_full),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .rx_data     (rx_data),
    .xfer_w      (xfer_w),
    .eng_state   (eng_state)
);

// File: tb/rx_oversample_uart_tb.sv
module rx_oversample_uart_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] char_len = 2'd1;
    logic [1:0] par_mode = 2'd0;
    logic       two_stop = 1'b0;
    logic       msb_first = 1'b0;
    logic       data_inv = 1'b0;
    logic       line_inv = 1'b0;
    logic       rts_en = 1'b1;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       buf_full, err_overrun, err_frame, err_parity, err_sum, rx_irq, rts_n;

    typedef struct packed { logic [8:0] d; logic pe; logic fe; } exp_t;
    exp_t exp_q[$];

    int  vecs = 0;
    int  fails = 0;
    int  irq_count = 0;
    bit  auto_read = 1'b1;
    bit  mon_rd = 1'b0;
    bit  finished = 1'b0;

    localparam int BITCLK = 32;  // 16 ticks, one tick per 2 clocks

    always #5 clk = ~clk;
    always @(posedge clk) tick16 <= ~tick16;

    rx_oversample_uart u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
        .char_len(char_len), .par_mode(par_mode), .two_stop(two_stop),
        .msb_first(msb_first), .data_inv(data_inv), .line_inv(line_inv),
        .rts_en(rts_en), .rxd(rxd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .buf_full(buf_full), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_parity(err_parity), .err_sum(err_sum),
        .rx_irq(rx_irq), .rts_n(rts_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        vecs++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    // monitor: pops expected items on each interrupt
    always @(negedge clk) begin
        if (mon_rd) begin
            rd_strobe = 1'b0;
            mon_rd = 1'b0;
        end
        if (rx_irq) begin
            irq_count++;
            if (exp_q.size() == 0) begin
                chk("R8 unexpected irq", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3/R4/R10/R11 data", {23'd0, rx_data}, {23'd0, e.d});
                chk("R5 parity flag", {31'd0, err_parity}, {31'd0, e.pe});
                chk("R6 frame flag", {31'd0, err_frame}, {31'd0, e.fe});
                chk("R9 sum flag", {31'd0, err_sum}, {31'd0, e.pe | e.fe});
            end
            if (auto_read) begin
                rd_strobe = 1'b1;
                mon_rd = 1'b1;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic lvl);
        rxd = lvl ^ line_inv;
    endtask

    task automatic stop_slot(input bit bad);
        if (bad) begin
            drive(1'b0); wait_clk(24);
            drive(1'b1); wait_clk(BITCLK - 24);
        end else begin
            drive(1'b1); wait_clk(BITCLK);
        end
    endtask

    // driver: builds the frame and pushes the expected item
    task automatic send_frame(input logic [8:0] d, input bit bad_par,
                              input bit bad_s1, input bit bad_s2, input bit expect_it);
        int nb;
        logic [8:0] mask;
        logic p;
        bit pen;
        exp_t e;
        nb   = (char_len == 2'd0) ? 7 : (char_len == 2'd2) ? 9 : 8;
        mask = 9'((1 << nb) - 1);
        pen  = (par_mode == 2'd1) || (par_mode == 2'd2);
        p    = ^(d & mask);
        if (par_mode == 2'd1) p = ~p;
        if (bad_par) p = ~p;
        if (expect_it) begin
            e.d  = d & mask;
            e.pe = pen && bad_par;
            e.fe = bad_s1 || (two_stop && bad_s2);
            exp_q.push_back(e);
        end
        @(negedge clk);
        drive(1'b0); wait_clk(BITCLK);
        for (int i = 0; i < nb; i++) begin
            int idx;
            idx = msb_first ? (nb - 1 - i) : i;
            drive(d[idx] ^ data_inv); wait_clk(BITCLK);
        end
        if (pen) begin
            drive(p ^ data_inv); wait_clk(BITCLK);
        end
        stop_slot(bad_s1);
        if (two_stop) stop_slot(bad_s2);
        drive(1'b1); wait_clk(2 * BITCLK);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    initial begin
        wait_clk(190000);
        chk("watchdog expired", 1, 0);
        summary();
    end

    initial begin
        int base;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // reset state
        chk("R8 reset buf_full", {31'd0, buf_full}, 0);
        chk("R8 reset irq", {31'd0, rx_irq}, 0);
        chk("R9 reset err_sum", {31'd0, err_sum}, 0);
        chk("R12 rts high while disabled", {31'd0, rts_n}, 1);
        // R1: frame while disabled is ignored
        base = irq_count;
        send_frame(9'h0A5, 0, 0, 0, 0);
        chk("R1 no irq while disabled", irq_count, base);
        chk("R1 buffer empty while disabled", {31'd0, buf_full}, 0);
        rx_en = 1'b1;
        wait_clk(2);
        chk("R12 rts low when ready", {31'd0, rts_n}, 0);
        rts_en = 1'b0; wait_clk(1);
        chk("R12 rts held high when off", {31'd0, rts_n}, 1);
        rts_en = 1'b1;

        // R3: lengths, LSB first
        send_frame(9'h0A5, 0, 0, 0, 1);
        send_frame(9'h03C, 0, 0, 0, 1);
        char_len = 2'd0; send_frame(9'h1FF, 0, 0, 0, 1);
        char_len = 2'd0; send_frame(9'h055, 0, 0, 0, 1);
        char_len = 2'd2; send_frame(9'h1A5, 0, 0, 0, 1);
        // R4: MSB first
        msb_first = 1'b1;
        char_len = 2'd1; send_frame(9'h0C1, 0, 0, 0, 1);
        char_len = 2'd2; send_frame(9'h103, 0, 0, 0, 1);
        char_len = 2'd0; send_frame(9'h041, 0, 0, 0, 1);
        msb_first = 1'b0; char_len = 2'd1;
        // R5: parity
        par_mode = 2'd2; send_frame(9'h0B7, 0, 0, 0, 1);
        par_mode = 2'd2; send_frame(9'h0B7, 1, 0, 0, 1);
        par_mode = 2'd1; send_frame(9'h0B7, 0, 0, 0, 1);
        par_mode = 2'd1; send_frame(9'h012, 1, 0, 0, 1);
        par_mode = 2'd3; send_frame(9'h0E1, 0, 0, 0, 1);
        par_mode = 2'd0;
        // R6: stop bits
        send_frame(9'h066, 0, 1, 0, 1);
        two_stop = 1'b1;
        send_frame(9'h099, 0, 0, 0, 1);
        send_frame(9'h099, 0, 0, 1, 1);
        send_frame(9'h0F0, 0, 1, 0, 1);
        // R10: data inversion with parity
        par_mode = 2'd2; data_inv = 1'b1;
        send_frame(9'h05A, 0, 0, 0, 1);
        send_frame(9'h0C3, 1, 0, 0, 1);
        data_inv = 1'b0; par_mode = 2'd0;
        // R11: line inversion
        @(negedge clk); line_inv = 1'b1; drive(1'b1); wait_clk(BITCLK);
        send_frame(9'h096, 0, 0, 0, 1);
        send_frame(9'h00F, 0, 0, 1, 1);
        @(negedge clk); line_inv = 1'b0; drive(1'b1); wait_clk(BITCLK);
        two_stop = 1'b0;

        // R2: glitch shorter than half a bit
        base = irq_count;
        @(negedge clk); drive(1'b0); wait_clk(8); drive(1'b1);
        wait_clk(6 * BITCLK);
        chk("R2 glitch no irq", irq_count, base);
        chk("R2 glitch buffer empty", {31'd0, buf_full}, 0);

        // R1: abort mid-frame
        base = irq_count;
        @(negedge clk); drive(1'b0); wait_clk(BITCLK);
        drive(1'b1); wait_clk(BITCLK);
        drive(1'b0); wait_clk(BITCLK / 2);
        rx_en = 1'b0; wait_clk(BITCLK);
        drive(1'b1); wait_clk(BITCLK);
        rx_en = 1'b1; wait_clk(10 * BITCLK);
        chk("R1 aborted frame no irq", irq_count, base);
        send_frame(9'h05C, 0, 0, 0, 1);

        // R7: overrun
        auto_read = 1'b0;
        send_frame(9'h011, 0, 0, 0, 1);
        chk("R8 buf_full after char", {31'd0, buf_full}, 1);
        chk("R12 rts high when full", {31'd0, rts_n}, 1);
        base = irq_count;
        send_frame(9'h022, 0, 0, 0, 0);
        chk("R7 overrun flag", {31'd0, err_overrun}, 1);
        chk("R7 sum with overrun", {31'd0, err_sum}, 1);
        chk("R7 data kept", {23'd0, rx_data}, 32'h011);
        chk("R7 no irq on overrun", irq_count, base);
        do_read(); wait_clk(1);
        chk("R9 overrun cleared", {31'd0, err_overrun}, 0);
        chk("R9 buf_full cleared", {31'd0, buf_full}, 0);
        chk("R9 sum cleared", {31'd0, err_sum}, 0);
        chk("R12 rts low after read", {31'd0, rts_n}, 0);

        // R9: read clears parity error
        par_mode = 2'd1;
        send_frame(9'h03A, 1, 0, 0, 1);
        chk("R9 parity flag held", {31'd0, err_parity}, 1);
        do_read(); wait_clk(1);
        chk("R9 parity cleared", {31'd0, err_parity}, 0);
        chk("R9 sum cleared after parity", {31'd0, err_sum}, 0);
        par_mode = 2'd0;
        auto_read = 1'b1;

        wait_clk(4);
        chk("R8 all expected chars seen", exp_q.size(), 0);
        summary();
    end
endmodule